// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bus slave sits behind a 32 MB alias window. Each 32-bit word slot in the window stands for a single bit of a backing memory region. A read of a slot returns that one bit. A write of a slot sets or clears it. The bridge turns every upstream access into downstream traffic on a master port. A read becomes one downstream read of the unit that holds the bit. A write becomes a locked read-modify-write of that unit.

Both the downstream address and the bit position come from the alias offset. Only the low 25 offset bits are decoded. The byte address of the unit is the base-address parameter ORed with the decoded offset shifted right by five, then aligned down to the access size. The bit index is taken from offset bits [6:2], masked to the width of the access.

A typical system uses two instances. One aliases an SRAM region at base 0x20000000 and is mapped at 0x22000000. The other aliases a peripheral region at base 0x40000000 and is mapped at 0x42000000. The bridge takes one request at a time and holds its request-ready low until it gives the response.

Top module: `bitband_bridge`

## Requirements
- R1: After reset the bridge is idle: `reqReady` is 1, `memValid` is 0 and `rspValid` is 0.
- R2: The downstream address is `BASE_ADDR | (reqAddr[24:0] >> 5)`, aligned down to a multiple of the access size. Offset bits 25 and above have no effect. The downstream size equals the request size.
- R3: The bit index is `reqAddr[6:2]` ANDed with (access size in bits − 1). The unit is carried on `memRdata`/`memWdata` with the byte at the lowest address in bits [7:0]. The selected bit is therefore at position (index/8)*8 + index%8 of that data.
- R4: A read request makes exactly one downstream read with `memLock` low and no downstream write. Its response carries the selected bit in `rspData[0]`, with every other bit 0 and `rspErr` 0.
- R5: A write request reads the aligned unit, then writes it back to the same address and size. The written unit equals the read unit, except that the selected bit equals `reqWdata[0]`.
- R6: Bits 31..1 of `reqWdata` have no effect on the unit written back.
- R7: An error on the downstream read ends the request at once with `rspErr` = 1. For a write request no write-back is issued.
- R8: An error on the downstream write-back is reported as `rspErr` = 1.
- R9: In a read-modify-write, `memLock` is high from the read until the write-back completes. The write-back request starts in the cycle right after the read completes.
- R10: `reqReady` is low from the cycle after acceptance until the response. `rspValid` is a single-cycle pulse, and `reqReady` is high again in the cycle after it.
- R11: Size code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. Size code 3 is answered with `rspErr` = 1 and no downstream access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Upstream request valid |
| reqReady | output | 1 | Upstream request accepted when high with reqValid |
| reqAddr | input | 32 | Offset into the alias window |
| reqSize | input | 2 | Access size code |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data; only bit 0 is used |
| rspValid | output | 1 | Response pulse |
| rspData | output | 32 | Read result (selected bit in bit 0) |
| rspErr | output | 1 | Response error flag |
| memValid | output | 1 | Downstream request valid |
| memReady | input | 1 | Downstream request completes |
| memAddr | output | 32 | Downstream byte address |
| memSize | output | 2 | Downstream size code |
| memWrite | output | 1 | Downstream write when high |
| memWdata | output | 32 | Downstream write unit |
| memLock | output | 1 | Holds the backing memory across the read-modify-write |
| memRdata | input | 32 | Downstream read unit, valid with memReady |
| memErr | input | 1 | Downstream error, valid with memReady |

## Verification
The bench builds the bridge with `BASE_ADDR` set to 0x40000000, the peripheral-region base. A dropped or misplaced base bit therefore shows up in every downstream address it captures. The window width stays at 25 bits, so offsets with bits 25 and 26 set fall outside the decode. They must alias onto the same unit as the plain offset. A 64-byte backing model with one-cycle response and an address-matched error injector covers all three sizes, reads and writes, and errors on both the fetch and the write-back.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } bbSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capReq;   // latch the accepted request
    logic capData;  // latch the fetched unit
    logic setErr;   // flag an error for the response
  } bbStrobe_t;

endpackage

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      reqSizeBad,
  output logic      reqReady,
  input  logic      memReady,
  input  logic      memErr,
  output logic      memValid,
  output logic      memWrite,
  output logic      memLock,
  output logic      rspValid,
  output bbStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_STORE, ST_REPLY} bbState_e;

  bbState_e state, stateNext;
  logic     opWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opWrite <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.capReq) opWrite <= reqWrite;
    end
  end

  always_comb begin
    stateNext = state;
    reqReady  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    memLock   = 1'b0;
    rspValid  = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capReq = 1'b1;
          if (reqSizeBad) begin
            strobe.setErr = 1'b1;
            stateNext     = ST_REPLY;
          end else begin
            stateNext = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        memValid = 1'b1;
        memLock  = opWrite;
        if (memReady) begin
          if (memErr) begin
            strobe.setErr = 1'b1;
            stateNext     = ST_REPLY;
          end else begin
            strobe.capData = 1'b1;
            stateNext      = opWrite ? ST_STORE : ST_REPLY;
          end
        end
      end
      ST_STORE: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        memLock  = 1'b1;
        if (memReady) begin
          strobe.setErr = memErr;
          stateNext     = ST_REPLY;
        end
      end
      ST_REPLY: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R9: a clean locked fetch is followed at once by the locked write-back
  assert_wb_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite && memLock && memReady && !memErr)
      |=> (memValid && memWrite && memLock));

  // R7: a failed fetch issues nothing further
  assert_no_wb_on_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite && memReady && memErr) |=> !memValid);

  // R10: response is a single pulse
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R10: no new request accepted while downstream traffic is live
  assert_one_inflight_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memValid && !rspValid));

  // R9: every downstream write is locked
  assert_write_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> memLock);

endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h2000_0000,
  parameter int          ADDR_W    = 32,
  parameter int          WINDOW_W  = 25,
  parameter int          DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bbStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);

  localparam int BYTES       = DATA_W / 8;
  localparam int BIT_W       = $clog2(DATA_W);
  localparam int STRIDE_LOG2 = 2;
  localparam int SHIFT       = STRIDE_LOG2 + 3;

  logic [WINDOW_W-1:0] offReg;
  logic [1:0]          sizeReg;
  logic                bitReg;
  logic [DATA_W-1:0]   unitReg;
  logic                errReg;

  logic [BYTES-1:0]    laneOn;
  logic [DATA_W-1:0]   laneMask;
  logic [ADDR_W-1:0]   rawAddr;
  logic [ADDR_W-1:0]   alignMask;
  logic [BIT_W-1:0]    idxMask;
  logic [BIT_W-1:0]    bitIdx;
  logic [DATA_W-1:0]   bitOneHot;

  for (genvar g = 0; g < BYTES; g++) begin : gLane
    assign laneOn[g] = (32'(g) < (32'd1 << sizeReg));
    assign laneMask[g*8 +: 8] = {8{laneOn[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg  <= '0;
      sizeReg <= '0;
      bitReg  <= 1'b0;
      unitReg <= '0;
      errReg  <= 1'b0;
    end else begin
      if (strobe.capReq) begin
        offReg  <= reqAddr[WINDOW_W-1:0];
        sizeReg <= reqSize;
        bitReg  <= reqWdata[0];
        errReg  <= strobe.setErr;
      end else if (strobe.setErr) begin
        errReg <= 1'b1;
      end
      if (strobe.capData) unitReg <= memRdata & laneMask;
    end
  end

  always_comb begin
    rawAddr   = BASE_ADDR | ADDR_W'(offReg >> SHIFT);
    alignMask = {ADDR_W{1'b1}} << sizeReg;
    idxMask   = BIT_W'((32'd8 << sizeReg) - 32'd1);
    bitIdx    = offReg[STRIDE_LOG2 +: BIT_W] & idxMask;
    bitOneHot = DATA_W'(1) << bitIdx;
  end

  assign memAddr  = rawAddr & alignMask;
  assign memSize  = sizeReg;
  assign memWdata = bitReg ? (unitReg | bitOneHot) : (unitReg & ~bitOneHot);
  assign rspData  = {{(DATA_W-1){1'b0}}, unitReg[bitIdx]};
  assign rspErr   = errReg;

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h2000_0000,
  parameter int          WINDOW_W  = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  input  logic [1:0]  reqSize,
  input  logic        reqWrite,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic        rspErr,
  output logic        memValid,
  input  logic        memReady,
  output logic [31:0] memAddr,
  output logic [1:0]  memSize,
  output logic        memWrite,
  output logic [31:0] memWdata,
  output logic        memLock,
  input  logic [31:0] memRdata,
  input  logic        memErr
);

  bbStrobe_t strobe;
  logic      sizeBad;

  assign sizeBad = (reqSize == SZ_BAD);

  bb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSizeBad (sizeBad),
    .reqReady   (reqReady),
    .memReady   (memReady),
    .memErr     (memErr),
    .memValid   (memValid),
    .memWrite   (memWrite),
    .memLock    (memLock),
    .rspValid   (rspValid),
    .strobe     (strobe)
  );

  bb_datapath #(
    .BASE_ADDR (BASE_ADDR),
    .ADDR_W    (32),
    .WINDOW_W  (WINDOW_W),
    .DATA_W    (32)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memSize  (memSize),
    .memWdata (memWdata),
    .rspData  (rspData),
    .rspErr   (rspErr)
  );

  // R2: downstream address is aligned to the access size
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> ((memSize == SZ_HALF) ? (memAddr[0] == 1'b0) :
                  (memSize == SZ_WORD) ? (memAddr[1:0] == 2'b00) : 1'b1));

  // R11: an illegal size never reaches the downstream port
  assert_no_bad_size_R11: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memSize != SZ_BAD));

  // R2: address and size are held across the whole request
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && $past(memValid)) |-> ($stable(memAddr) && $stable(memSize)));

endmodule

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/1ps
module bitband_bridge_bench;

  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspErr;
  logic        memValid;
  logic        memReady;
  logic [31:0] memAddr;
  logic [1:0]  memSize;
  logic        memWrite;
  logic [31:0] memWdata;
  logic        memLock;
  logic [31:0] memRdata;
  logic        memErr;

  always #10 clk = ~clk;

  bitband_bridge #(.BASE_ADDR(BASE), .WINDOW_W(25)) u_bitband_bridge (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memSize(memSize), .memWrite(memWrite), .memWdata(memWdata),
    .memLock(memLock), .memRdata(memRdata), .memErr(memErr)
  );

  // Backing memory model with error injection
  logic        errArm = 1'b0;
  logic        errOnWrite = 1'b0;
  logic [31:0] errAddr = '0;
  logic        clrStat = 1'b0;
  logic [7:0]  mem [64];
  logic        hit;
  int          nb;

  assign hit = errArm && (memAddr == errAddr) && (memWrite == errOnWrite);
  assign nb  = 1 << memSize;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReady <= 1'b0;
      memErr   <= 1'b0;
      memRdata <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 37 + 5);
    end else if (memValid && !memReady) begin
      memReady <= 1'b1;
      memErr   <= hit;
      if (!memWrite) begin
        for (int k = 0; k < 4; k++)
          memRdata[8*k +: 8] <= (k < nb) ? mem[6'(int'(memAddr[5:0]) + k)] : 8'h00;
      end else if (!hit) begin
        for (int k = 0; k < 4; k++)
          if (k < nb) mem[6'(int'(memAddr[5:0]) + k)] <= memWdata[8*k +: 8];
      end
    end else begin
      memReady <= 1'b0;
      memErr   <= 1'b0;
    end
  end

  // Downstream traffic log
  int          rdCount, wrCount;
  logic [31:0] lastRdAddr, lastWrAddr, lastWrData;
  logic [1:0]  lastRdSize, lastWrSize;
  logic        lockOnRead;

  always_ff @(posedge clk) begin
    if (!rstN || clrStat) begin
      rdCount <= 0; wrCount <= 0; lockOnRead <= 1'b0;
      lastRdAddr <= '0; lastWrAddr <= '0; lastWrData <= '0;
      lastRdSize <= '0; lastWrSize <= '0;
    end else if (memValid && memReady) begin
      if (!memWrite) begin
        rdCount <= rdCount + 1; lastRdAddr <= memAddr;
        lastRdSize <= memSize; lockOnRead <= memLock;
      end else begin
        wrCount <= wrCount + 1; lastWrAddr <= memAddr;
        lastWrSize <= memSize; lastWrData <= memWdata;
      end
    end
  end

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [64];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input logic [31:0] off, input logic [1:0] sz);
    logic [31:0] a;
    a = BASE | ((off & 32'h01FF_FFFF) >> 5);
    return a & ~((32'd1 << sz) - 32'd1);
  endfunction

  function automatic int expIdx(input logic [31:0] off, input logic [1:0] sz);
    return int'((off >> 2) & ((32'd8 << sz) - 32'd1));
  endfunction

  function automatic logic [31:0] shadowUnit(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] u = '0;
    for (int k = 0; k < 4; k++)
      if (k < (1 << sz)) u[8*k +: 8] = shadow[6'(int'(a[5:0]) + k)];
    return u;
  endfunction

  logic [31:0] gotData;
  logic        gotErr, gotRsp, busyReady;

  task automatic runTxn(input logic w, input logic [1:0] sz, input logic [31:0] off,
                        input logic [31:0] wd);
    int waitCyc;
    @(negedge clk);
    clrStat = 1'b1; reqValid = 1'b1; reqWrite = w; reqSize = sz;
    reqAddr = off; reqWdata = wd;
    @(negedge clk);
    clrStat = 1'b0; reqValid = 1'b0; busyReady = 1'b0; waitCyc = 0;
    while (!rspValid && waitCyc < 50) begin
      if (reqReady) busyReady = 1'b1;
      @(negedge clk);
      waitCyc++;
    end
    gotRsp = rspValid; gotData = rspData; gotErr = rspErr;
  endtask

  // {write, size, offset, wdata}
  localparam logic [66:0] VEC [12] = '{
    {1'b0, 2'd0, 32'h0000_0004, 32'h0},
    {1'b1, 2'd2, 32'h0000_0064, 32'h1},
    {1'b0, 2'd2, 32'h0000_0064, 32'h0},
    {1'b1, 2'd1, 32'h0000_017C, 32'hFFFF_FFFE},
    {1'b0, 2'd1, 32'h0000_017C, 32'h0},
    {1'b1, 2'd0, 32'h0600_03E0, 32'h3},
    {1'b0, 2'd0, 32'h0000_03E0, 32'h0},
    {1'b1, 2'd2, 32'h0000_07FC, 32'h8000_0001},
    {1'b0, 2'd2, 32'h0000_07FC, 32'h0},
    {1'b0, 2'd1, 32'h0000_0022, 32'h0},
    {1'b1, 2'd0, 32'h0000_0010, 32'h0},
    {1'b0, 2'd0, 32'h0000_FFFC, 32'h0}
  };

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(reqReady && !memValid && !rspValid, "R1",
        {29'b0, reqReady, memValid, rspValid}, 32'h4);

    for (int v = 0; v < 12; v++) begin
      logic        w;
      logic [1:0]  sz;
      logic [31:0] off, wd, ea, unit, expUnit, mask;
      int          idx;
      logic        expBit;
      {w, sz, off, wd} = VEC[v];
      ea   = expAddr(off, sz);
      idx  = expIdx(off, sz);
      unit = shadowUnit(ea, sz);
      expBit = unit[idx];                       // R3 position
      mask = (sz == 2'd2) ? 32'hFFFF_FFFF : ((32'd1 << (8 << sz)) - 32'd1);
      runTxn(w, sz, off, wd);
      chk(gotRsp && !gotErr, "R10", {31'b0, gotErr}, 32'h0);
      chk(!busyReady, "R10", {31'b0, busyReady}, 32'h0);
      chk(lastRdAddr == ea && lastRdSize == sz && rdCount == 1, "R2", lastRdAddr, ea);
      if (!w) begin
        chk(gotData == {31'b0, expBit}, "R3", gotData, {31'b0, expBit});
        chk(wrCount == 0 && !lockOnRead, "R4", {wrCount[30:0], lockOnRead}, 32'h0);
      end else begin
        expUnit = unit;
        expUnit[idx] = wd[0];
        chk(wrCount == 1 && lastWrAddr == ea && lastWrSize == sz, "R5", lastWrAddr, ea);
        // R6 when upper write-data bits are set
        chk((lastWrData & mask) == expUnit, (wd[31:1] != 0) ? "R6" : "R5",
            lastWrData & mask, expUnit);
        chk(lockOnRead, "R9", {31'b0, lockOnRead}, 32'h1);
        for (int k = 0; k < 4; k++)
          if (k < (1 << sz)) shadow[6'(int'(ea[5:0]) + k)] = expUnit[8*k +: 8];
      end
    end

    // R10: pulse then ready again
    @(negedge clk);
    chk(!rspValid && reqReady, "R10", {30'b0, rspValid, reqReady}, 32'h1);

    // R11: illegal size
    runTxn(1'b0, 2'd3, 32'h0000_0040, 32'h0);
    chk(gotRsp && gotErr && rdCount == 0 && wrCount == 0, "R11",
        {30'b0, gotErr, 1'(rdCount + wrCount)}, 32'h2);

    // R7: fetch error on a read
    errArm = 1'b1; errOnWrite = 1'b0; errAddr = expAddr(32'h0000_0100, 2'd0);
    runTxn(1'b0, 2'd0, 32'h0000_0100, 32'h0);
    chk(gotRsp && gotErr && wrCount == 0, "R7", {31'b0, gotErr}, 32'h1);

    // R7: fetch error on a write, no write-back, memory unchanged
    runTxn(1'b1, 2'd0, 32'h0000_0104, 32'h1);
    chk(gotErr && wrCount == 0, "R7", {wrCount[30:0], gotErr}, 32'h1);
    errArm = 1'b0;
    begin
      logic [31:0] u;
      u = shadowUnit(expAddr(32'h0000_0104, 2'd0), 2'd0);
      runTxn(1'b0, 2'd0, 32'h0000_0104, 32'h0);
      chk(gotData == {31'b0, u[1]}, "R7", gotData, {31'b0, u[1]});
    end

    // R8: write-back error
    errArm = 1'b1; errOnWrite = 1'b1; errAddr = expAddr(32'h0000_0200, 2'd1);
    runTxn(1'b1, 2'd1, 32'h0000_0200, 32'h1);
    chk(gotErr && wrCount == 1, "R8", {wrCount[30:0], gotErr}, 32'h3);
    errArm = 1'b0;
    begin
      logic [31:0] u;
      u = shadowUnit(expAddr(32'h0000_0200, 2'd1), 2'd1);
      runTxn(1'b0, 2'd1, 32'h0000_0200, 32'h0);
      chk(!gotErr && gotData == {31'b0, u[0]}, "R8", gotData, {31'b0, u[0]});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule